// File: doc/BRIEF.md
# Vector Rotate-and-Mask Unit

This unit treats a 128-bit vector as independent lanes, either four 32-bit lanes or two 64-bit lanes. In each lane a source element is rotated left. A control element from a second vector gives three things: the rotate count, the first bit of a mask and the last bit of that mask. The mask is a run of ones between those two bit positions. When the first position lies after the last, the run wraps around the lane.

The unit has two merge modes. In AND mode, bits outside the mask are cleared. In insert mode, the masked bits of the rotated value replace the matching bits of a third vector, which holds the old destination contents. All lanes are computed in parallel in one combinational pass. A parameter selects an optional output register, which adds one cycle of latency.

Top module: `vrotmask_unit`

## Requirements
- R1: With `wide_sel`=0 the vector is four 32-bit lanes, lane k occupying bits 32k+31..32k. With `wide_sel`=1 it is two 64-bit lanes, lane k occupying bits 64k+63..64k. Lanes never affect one another.
- R2: Each lane rotates its `src_a` element left by the unsigned count in bits 5..0 of its `ctl_b` element. In 32-bit lanes only bits 4..0 are used. A count of 0 leaves the element unrotated.
- R3: Mask positions are numbered from the lane MSB, which is position 0, to the LSB, which is position N-1. The start position is taken from control bits 21..16 and the end position from control bits 13..8. When start <= end, exactly positions start..end are set, so start == end gives a single bit. In 32-bit lanes both fields are taken modulo 32.
- R4: When start > end, the mask is set at every position >= start and every position <= end. A start of end+1 therefore gives an all-ones mask.
- R5: With `ins_sel`=0 (AND mode), each lane yields the rotated value ANDed with the mask, and `old_c` has no effect.
- R6: With `ins_sel`=1 (insert mode), each lane yields (rotated AND mask) OR (`old_c` AND NOT mask).
- R7: Control bits outside the three fields have no effect on the result.
- R8: With the default registered output, a result is presented with `out_valid`=1 one cycle after `in_valid`. `res` holds its value while `in_valid` is low. Reset clears `out_valid` and `res` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| wide_sel | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| ins_sel | input | 1 | 0: AND mode, 1: insert mode |
| src_a | input | 128 | Elements to rotate |
| ctl_b | input | 128 | Per-lane control (count, mask end, mask start) |
| old_c | input | 128 | Prior destination contents for insert mode |
| out_valid | output | 1 | Result valid |
| res | output | 128 | Result vector |

## Verification
The lane assertions are gated by `in_valid`. They therefore assume that all three operand vectors and both mode selects hold known values whenever `in_valid` is high. They also assume that both lane widths are computed on every operation, whatever `wide_sel` says. The stimulus drives every input to a defined value from time zero, including during idle cycles. It changes operands only on the falling clock edge. Random patterns fill the control bits outside the three fields, and the field values include counts and bounds above 31 in 32-bit lanes, so all of these cases reach the lanes.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int unsigned VEC_BITS = 128;
  localparam int unsigned NAR_BITS = 32;
  localparam int unsigned WID_BITS = 64;
  localparam int unsigned AMT_LSB  = 0;
  localparam int unsigned FIN_LSB  = 8;
  localparam int unsigned BEG_LSB  = 16;

  typedef enum logic { LANES_NARROW = 1'b0, LANES_WIDE = 1'b1 } lane_mode_e;
  typedef enum logic { MERGE_AND = 1'b0, MERGE_INSERT = 1'b1 } merge_mode_e;

  // Run of ones from big-endian position beg to fin, complemented on wrap.
  function automatic logic [WID_BITS-1:0] span_bits(input int unsigned w,
                                                    input int unsigned beg,
                                                    input int unsigned fin);
    logic [WID_BITS-1:0] ones;
    logic [WID_BITS-1:0] upper;
    logic [WID_BITS-1:0] lower;
    ones  = (w == WID_BITS) ? '1 : ((WID_BITS'(1) << w) - 1'b1);
    upper = ones >> beg;
    lower = (ones >> fin) >> 1;
    return (beg > fin) ? (~(upper ^ lower) & ones) : (upper ^ lower);
  endfunction
endpackage

// File: rtl/vrm_mask.sv
module vrm_mask #(
  parameter int unsigned W    = 32,
  localparam int unsigned IDXW = $clog2(W)
) (
  input  logic [IDXW-1:0] beg,
  input  logic [IDXW-1:0] fin,
  output logic [W-1:0]    mask,
  output logic            wrap
);
  import vrm_pkg::*;
  logic [WID_BITS-1:0] full;

  always_comb begin
    full = span_bits(W, int'(beg), int'(fin));
    mask = full[W-1:0];
    wrap = (beg > fin);
  end

  if (W < WID_BITS) begin : g_trim
    logic unused_hi;
    assign unused_hi = ^full[WID_BITS-1:W];
  end
endmodule

// File: rtl/vrm_rot.sv
module vrm_rot #(
  parameter int unsigned W    = 32,
  localparam int unsigned IDXW = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [IDXW-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [2*W-1:0] dbl;

  always_comb begin
    dbl  = {din, din} << amt;
    dout = dbl[2*W-1:W];
  end
endmodule

// File: rtl/vrm_lane.sv
module vrm_lane #(
  parameter int unsigned W    = 32,
  localparam int unsigned IDXW = $clog2(W)
) (
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    ctl,
  input  logic [W-1:0]    old,
  input  logic            ins,
  output logic [W-1:0]    res,
  output logic [W-1:0]    mask,
  output logic [W-1:0]    rot,
  output logic            wrap,
  output logic [IDXW-1:0] beg,
  output logic [IDXW-1:0] fin
);
  import vrm_pkg::*;
  logic [IDXW-1:0] amt;
  logic            unused_ctl;

  assign amt        = ctl[AMT_LSB +: IDXW];
  assign fin        = ctl[FIN_LSB +: IDXW];
  assign beg        = ctl[BEG_LSB +: IDXW];
  assign unused_ctl = ^ctl;

  vrm_rot #(.W(W)) u_rot (.din(src), .amt(amt), .dout(rot));
  vrm_mask #(.W(W)) u_mask (.beg(beg), .fin(fin), .mask(mask), .wrap(wrap));

  always_comb begin
    if (merge_mode_e'(ins) == MERGE_INSERT) res = (rot & mask) | (old & ~mask);
    else                                    res = rot & mask;
  end
endmodule

// File: rtl/vrm_laneset.sv
module vrm_laneset #(
  parameter int unsigned VW   = 128,
  parameter int unsigned W    = 32,
  localparam int unsigned NL   = VW / W,
  localparam int unsigned IDXW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          ins,
  input  logic [VW-1:0] src,
  input  logic [VW-1:0] ctl,
  input  logic [VW-1:0] old,
  output logic [VW-1:0] res
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [W-1:0]    l_res, l_mask, l_rot, l_old;
    logic            l_wrap;
    logic [IDXW-1:0] l_beg, l_fin;

    assign l_old = old[i*W +: W];

    vrm_lane #(.W(W)) u_lane (
      .src (src[i*W +: W]),
      .ctl (ctl[i*W +: W]),
      .old (l_old),
      .ins (ins),
      .res (l_res),
      .mask(l_mask),
      .rot (l_rot),
      .wrap(l_wrap),
      .beg (l_beg),
      .fin (l_fin)
    );
    assign res[i*W +: W] = l_res;

    // R5
    and_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !ins) |-> ((l_res & ~l_mask) == '0));
    // R6
    insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && ins) |-> ((l_res & ~l_mask) == (l_old & ~l_mask)));
    // R2
    rot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ((l_res & l_mask) == (l_rot & l_mask)));
    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && (l_beg == l_fin)) |-> ($countones(l_mask) == 1));
    // R4
    wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && l_wrap && (l_beg == l_fin + 1'b1)) |-> (&l_mask));
  end
endmodule

// File: rtl/vrm_stage.sv
module vrm_stage #(
  parameter int unsigned W       = 128,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (vld_d) dat_q <= dat_d;
      end
    end
    assign vld_o = vld_q;
    assign dat_o = dat_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_d |=> $stable(dat_o));
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_d |=> vld_o);
  end else begin : g_thru
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign vld_o = vld_d;
    assign dat_o = dat_d;
  end
endmodule

// File: rtl/vrotmask_unit.sv
module vrotmask_unit #(
  parameter int unsigned VEC_W   = vrm_pkg::VEC_BITS,
  parameter int unsigned NAR_W   = vrm_pkg::NAR_BITS,
  parameter int unsigned WID_W   = vrm_pkg::WID_BITS,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             wide_sel,
  input  logic             ins_sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] ctl_b,
  input  logic [VEC_W-1:0] old_c,
  output logic             out_valid,
  output logic [VEC_W-1:0] res
);
  import vrm_pkg::*;
  logic [VEC_W-1:0] nar_res, wid_res, sel_res;

  vrm_laneset #(.VW(VEC_W), .W(NAR_W)) u_nar (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid), .ins(ins_sel),
    .src(src_a), .ctl(ctl_b), .old(old_c), .res(nar_res)
  );

  vrm_laneset #(.VW(VEC_W), .W(WID_W)) u_wid (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid), .ins(ins_sel),
    .src(src_a), .ctl(ctl_b), .old(old_c), .res(wid_res)
  );

  assign sel_res = (lane_mode_e'(wide_sel) == LANES_WIDE) ? wid_res : nar_res;

  vrm_stage #(.W(VEC_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .vld_d(in_valid), .dat_d(sel_res),
    .vld_o(out_valid), .dat_o(res)
  );
endmodule

// File: tb/sim_vrotmask_unit.sv
module sim_vrotmask_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, wide_sel = 1'b0, ins_sel = 1'b0;
  logic [127:0] src_a = '0, ctl_b = '0, old_c = '0;
  logic         out_valid;
  logic [127:0] res;

  int errors = 0;
  int checks = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;

  vrotmask_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
    .ins_sel(ins_sel), .src_a(src_a), .ctl_b(ctl_b), .old_c(old_c),
    .out_valid(out_valid), .res(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Independent bit-level model of the requirements
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c, input bit w, input bit ins);
    logic [127:0] r = '0;
    int n = w ? 64 : 32;
    for (int k = 0; k < 128 / n; k++) begin
      int base = k * n;
      logic [63:0] bl = '0;
      int amt, fin, beg;
      for (int j = 0; j < n; j++) bl[j] = b[base + j];
      amt = int'(bl[5:0]) % n;
      fin = int'(bl[13:8]) % n;
      beg = int'(bl[21:16]) % n;
      for (int j = 0; j < n; j++) begin
        int p = n - 1 - j;
        int s = (j - amt + n) % n;
        bit inm = (beg <= fin) ? (p >= beg && p <= fin) : (p >= beg || p <= fin);
        r[base + j] = inm ? a[base + s] : (ins ? c[base + j] : 1'b0);
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] fld(input int beg, input int fin, input int amt);
    return (64'(beg & 63) << 16) | (64'(fin & 63) << 8) | 64'(amt & 63);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                       input bit w, input bit ins, input string tag);
    @(negedge clk);
    src_a = a; ctl_b = b; old_c = c; wide_sel = w; ins_sel = ins; in_valid = 1'b1;
    last_exp = model(a, b, c, w, ins);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = rnd128(); ctl_b = rnd128(); old_c = rnd128();
  endtask

  // Same control element in every lane of the chosen width
  task automatic corner(input int beg, input int fin, input int amt, input bit w,
                        input bit ins, input string tag);
    logic [63:0] e = fld(beg, fin, amt);
    logic [127:0] b = w ? {2{e}} : {4{e[31:0]}};
    drive(rnd128(), b, rnd128(), w, ins, tag);
  endtask

  // Monitor: compare results against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R8 unexpected out_valid act=1 exp=0");
      end else begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, res, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {127'b0, out_valid}, '0);
    chk("R8 reset res", res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int wi = 0; wi < 2; wi++) begin
      bit w = bit'(wi);
      int n = w ? 64 : 32;
      corner(0, n-1, 0, w, 0, "R3 full span no rotate");
      corner(7, 7, 3, w, 0, "R3 single bit");
      corner(4, n-3, 1, w, 1, "R3 inner span insert");
      corner(10, 9, 5, w, 0, "R4 wrap all ones");
      corner(n-1, 0, 0, w, 1, "R4 wrap two bits insert");
      corner(20, 3, n-1, w, 0, "R2 max rotate wrap");
      corner(0, 12, 0, w, 1, "R6 start zero insert");
      corner(5, n-1, 9, w, 0, "R5 end at lsb");
      corner(0, n-1, 17, w, 1, "R6 full mask insert");
    end
    corner(40, 50, 37, 1'b0, 0, "R3 narrow fields modulo 32");
    corner(63, 33, 63, 1'b0, 1, "R2 narrow count low five bits");
    drive(rnd128(), {4{32'hFFC0_C0C0}} | {4{fld(3, 20, 6)}}, rnd128(), 1'b0, 0,
          "R7 junk bits narrow");
    drive(rnd128(), {2{64'hFFFF_FFFF_FFC0_C0C0 | fld(60, 2, 33)}}, rnd128(), 1'b1, 1,
          "R7 junk bits wide");
    drive(rnd128(), {fld(1, 2, 3), fld(40, 8, 60)}, rnd128(), 1'b1, 0, "R1 wide lanes differ");
    drive(rnd128(), {fld(0, 31, 0), fld(16, 15, 8)} | {32'h0, fld(9, 9, 31)} << 32,
          rnd128(), 1'b0, 1, "R1 narrow lanes differ");

    for (int i = 0; i < 400; i++) begin
      bit w = bit'($urandom_range(0, 1));
      bit ins = bit'($urandom_range(0, 1));
      drive(rnd128(), rnd128(), rnd128(), w, ins, ins ? "R6 random insert" : "R5 random and");
      if ($urandom_range(0, 3) == 0) idle();
    end

    idle();
    repeat (4) idle();
    chk("R8 hold while idle", res, last_exp);
    chk("R8 queue drained", 128'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule